// File: doc/BRIEF.md
# Three-Wire Serial Gain and Channel Controller

This block is the digital control core of a programmable-gain amplifier whose serial port has one shared data pin. A host sends 16-bit command words with a serial clock, an active-low select and a single data line. The block oversamples those pins with its own system clock and counts the serial clock cycles in each select window. It acts on a command only when the select pin rises and the clock count is a nonzero multiple of 16. A window with any other count is dropped whole, which also gives the host a quick way to bring the port back into step.

The block holds a 4-bit gain code and a 4-bit channel code, and a shutdown flag kept apart from them. A read command arms the port. The next frame then turns the shared pin around and shifts the held codes out, most significant bit first. There is no data stream with back-pressure at the edge: the host paces every bit with its clock. All pins are plain levels, and the outputs are registered codes and flags. The pad that combines `dio_out` and `dio_oe` into one pin sits outside.

Top module: `spi3_gain_ctrl`

## Requirements
- R1: After reset, `gain_code` and `chan_code` are 0, `shutdown` is 0 and `dio_oe` is 0.
- R2: A frame whose last 16 bits carry 0x2A in bits 15:8 loads bits 7:4 into `gain_code` and bits 3:0 into `chan_code`. Outputs change only after `cs_n` rises, never during the frame.
- R3: A frame with 0, or with any count of rising `sclk` edges that is not a multiple of 16, changes no output and no pending state.
- R4: In a frame of 32 or more clocks, only the last 16 bits shifted in (MSB first) are decoded.
- R5: Word 0xE1F1 sets `shutdown` to 1 and leaves `gain_code` and `chan_code` unchanged.
- R6: Word 0xE100 clears `shutdown` and keeps the stored codes. Any valid write also clears `shutdown`.
- R7: After the word 0x6A00, the next valid frame drives the word {0x00, gain, chan} on `dio_out`, MSB first. The first bit is present before the first rising `sclk` edge. Each further bit changes only after a falling edge that follows a rising edge.
- R8: `dio_oe` is 1 only while `cs_n` is low in a frame that follows a valid read. The incoming bits of that frame are ignored, and the frame ends the armed state. An invalid-length frame after a read leaves it armed.
- R9: Mode 0,0 (`sclk` idle low) and mode 1,1 (`sclk` idle high) give identical results. In mode 1,1 the falling edge before the first rise does not shift data.
- R10: Word 0x0000, 0x6A words with a nonzero low byte, and every other unlisted word leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| dio_in | input | 1 | Data pin as seen by the input buffer |
| dio_out | output | 1 | Read-back data toward the pad driver |
| dio_oe | output | 1 | Drive enable for the pad driver |
| gain_code | output | 4 | Stored gain selection code |
| chan_code | output | 4 | Stored channel selection code |
| shutdown | output | 1 | Shutdown flag |

## Verification
The bench builds the block with three synchronizer stages rather than the default two, so every pin change reaches the logic one cycle later. Its per-cycle comparison skips a settle window after each pin change and checks that the stored codes never move before the select edge. The serial half-period is 12 system clocks. That is long enough for edges at both idle levels to be resolved one at a time, and for 32-clock frames and turned-around read frames to run within the cycle budget.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int WORD_W = 16;
  localparam int GAIN_W = 4;
  localparam int CHAN_W = 4;
  localparam int OP_W   = WORD_W - GAIN_W - CHAN_W;
  localparam int CNT_W  = $clog2(WORD_W);

  localparam logic [OP_W-1:0]   OP_WRITE  = 8'h2A;
  localparam logic [WORD_W-1:0] W_READ    = 16'h6A00;
  localparam logic [WORD_W-1:0] W_NOP     = 16'h0000;
  localparam logic [WORD_W-1:0] W_SDN_ON  = 16'hE1F1;
  localparam logic [WORD_W-1:0] W_SDN_OFF = 16'hE100;

  typedef enum logic [2:0] {
    CMD_OTHER,
    CMD_NOP,
    CMD_WRITE,
    CMD_READ,
    CMD_SLEEP,
    CMD_WAKE
  } cmd_e;

  function automatic cmd_e decode_word(input logic [WORD_W-1:0] w);
    cmd_e c;
    if (w[WORD_W-1 -: OP_W] == OP_WRITE) c = CMD_WRITE;
    else if (w == W_READ)    c = CMD_READ;
    else if (w == W_SDN_ON)  c = CMD_SLEEP;
    else if (w == W_SDN_OFF) c = CMD_WAKE;
    else if (w == W_NOP)     c = CMD_NOP;
    else                     c = CMD_OTHER;
    return c;
  endfunction
endpackage

// File: rtl/spi3_pin_sync.sv
module spi3_pin_sync #(
  parameter int          STAGES  = 2,
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], pin_i[b]};
    end
    assign lvl_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi3_edge_detect.sv
module spi3_edge_detect #(
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev;
  assign fall_o = ~lvl_i & prev;
endmodule

// File: rtl/spi3_frame_rx.sv
module spi3_frame_rx
  import spi3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              cs_start,
  input  logic              cs_end,
  input  logic              sclk_rise,
  input  logic              din,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o,
  output logic              seen_rise_o
);
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              full;
  logic              seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      full    <= 1'b0;
      seen    <= 1'b0;
    end else if (!cs_active) begin
      bit_cnt <= '0;
      full    <= 1'b0;
      seen    <= 1'b0;
    end else if (sclk_rise) begin
      shreg   <= {shreg[WORD_W-2:0], din};
      bit_cnt <= bit_cnt + 1'b1;
      seen    <= 1'b1;
      if (bit_cnt == CNT_W'(WORD_W - 1)) full <= 1'b1;
    end
  end

  assign word_o      = shreg;
  assign seen_rise_o = seen;
  assign commit_o    = cs_end && full && (bit_cnt == '0);

  // R3: each frame begins with a cleared count and no completed word
  p_fresh_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |-> (bit_cnt == '0 && !full));
endmodule

// File: rtl/spi3_tx_shift.sv
module spi3_tx_shift
  import spi3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              sclk_fall,
  input  logic              seen_rise,
  input  logic [GAIN_W-1:0] gain,
  input  logic [CHAN_W-1:0] chan,
  output logic              bit_o
);
  logic [WORD_W-1:0] txreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      txreg <= '0;
    else if (!cs_active)
      txreg <= {{OP_W{1'b0}}, gain, chan};
    else if (sclk_fall && seen_rise)
      txreg <= {txreg[WORD_W-2:0], 1'b0};
  end

  assign bit_o = txreg[WORD_W-1];

  // R7: inside a frame the output bit moves only on a falling clock edge
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && !sclk_fall) |=> $stable(bit_o));
endmodule

// File: rtl/spi3_cfg_regs.sv
module spi3_cfg_regs
  import spi3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output logic [GAIN_W-1:0] gain_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              sdn_o,
  output logic              pend_o
);
  cmd_e cmd;
  assign cmd = decode_word(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_o <= '0;
      chan_o <= '0;
      sdn_o  <= 1'b0;
      pend_o <= 1'b0;
    end else if (commit) begin
      if (pend_o) begin
        pend_o <= 1'b0;
      end else begin
        pend_o <= (cmd == CMD_READ);
        unique case (cmd)
          CMD_WRITE: begin
            gain_o <= word[GAIN_W+CHAN_W-1:CHAN_W];
            chan_o <= word[CHAN_W-1:0];
            sdn_o  <= 1'b0;
          end
          CMD_SLEEP: sdn_o <= 1'b1;
          CMD_WAKE:  sdn_o <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R2: codes hold between accepted frames
  p_codes_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(gain_o) && $stable(chan_o)));
  // R5: shutdown flag holds between accepted frames
  p_sdn_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(sdn_o));
  // R5: the shutdown word takes effect
  p_sdn_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !pend_o && word == W_SDN_ON) |=> sdn_o);
  // R8: a read-back frame consumes the armed state
  p_readout_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && pend_o) |=> !pend_o);
endmodule

// File: rtl/spi3_gain_ctrl.sv
module spi3_gain_ctrl
  import spi3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              dio_in,
  output logic              dio_out,
  output logic              dio_oe,
  output logic [GAIN_W-1:0] gain_code,
  output logic [CHAN_W-1:0] chan_code,
  output logic              shutdown
);
  localparam logic [2:0] PIN_RST  = 3'b010;
  localparam logic [1:0] EDGE_RST = 2'b10;

  logic [2:0]        pin_lvl;
  logic [1:0]        edge_rise;
  logic [1:0]        edge_fall;
  logic              cs_active;
  logic [WORD_W-1:0] rx_word;
  logic              commit;
  logic              seen_rise;
  logic              pend;

  spi3_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({dio_in, cs_n, sclk}),
    .lvl_o (pin_lvl)
  );

  spi3_edge_detect #(.WIDTH(2), .RST_VAL(EDGE_RST)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (pin_lvl[1:0]),
    .rise_o (edge_rise),
    .fall_o (edge_fall)
  );

  assign cs_active = ~pin_lvl[1];

  spi3_frame_rx u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_active   (cs_active),
    .cs_start    (edge_fall[1]),
    .cs_end      (edge_rise[1]),
    .sclk_rise   (edge_rise[0]),
    .din         (pin_lvl[2]),
    .word_o      (rx_word),
    .commit_o    (commit),
    .seen_rise_o (seen_rise)
  );

  spi3_cfg_regs u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .word   (rx_word),
    .gain_o (gain_code),
    .chan_o (chan_code),
    .sdn_o  (shutdown),
    .pend_o (pend)
  );

  spi3_tx_shift u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_active (cs_active),
    .sclk_fall (edge_fall[0]),
    .seen_rise (seen_rise),
    .gain      (gain_code),
    .chan      (chan_code),
    .bit_o     (dio_out)
  );

  assign dio_oe = pend && cs_active;

  // R8: the armed state only changes when a frame is accepted
  p_pend_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(pend));
endmodule

// File: tb/spi3_gain_ctrl_tb.sv
module spi3_gain_ctrl_tb;
  localparam int SYNC   = 3;
  localparam int HALF   = 12;
  localparam int SETTLE = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic dio_in = 1'b0;
  logic dio_out, dio_oe, shutdown;
  logic [3:0] gain_code, chan_code;

  always #4 clk = ~clk;

  spi3_gain_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .dio_in(dio_in),
    .dio_out(dio_out), .dio_oe(dio_oe), .gain_code(gain_code),
    .chan_code(chan_code), .shutdown(shutdown)
  );

  int checks = 0;
  int fails = 0;
  int quiet = 0;
  int cycles = 0;
  bit cmp_on = 0;
  bit done = 0;

  int ex_gain = 0, ex_chan = 0, ex_sdn = 0, ex_pend = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    if (quiet < 100000) quiet = quiet + 1;
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog: actual %0d expected below %0d", cycles, 150000);
      summary();
      $finish;
    end
  end

  // per-cycle comparison against the behavioural model once pins are settled
  always @(negedge clk) begin
    #2;
    if (cmp_on && quiet > SETTLE) begin
      chk("R2", "gain each cycle", int'(gain_code), ex_gain);
      chk("R2", "chan each cycle", int'(chan_code), ex_chan);
      chk("R5", "shutdown each cycle", int'(shutdown), ex_sdn);
      chk("R8", "oe each cycle", int'(dio_oe), (ex_pend != 0 && cs_n == 1'b0) ? 1 : 0);
    end
  end

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_idle(bit mode11);
    sclk = mode11;
    quiet = 0;
    waitc(2 * HALF);
  endtask

  // model of one frame end
  task automatic model_end(int n, logic [63:0] stream, logic [15:0] cap);
    logic [15:0] w;
    if (n == 0 || (n % 16) != 0) return;
    if (ex_pend != 0) begin
      chk("R7", "read-back word", int'(cap), (ex_gain << 4) | ex_chan);
      ex_pend = 0;
      return;
    end
    w = stream[15:0];
    if (w[15:8] == 8'h2A) begin
      ex_gain = int'(w[7:4]);
      ex_chan = int'(w[3:0]);
      ex_sdn = 0;
    end else if (w == 16'hE1F1) ex_sdn = 1;
    else if (w == 16'hE100) ex_sdn = 0;
    ex_pend = (w == 16'h6A00) ? 1 : 0;
  endtask

  task automatic frame(bit mode11, int n, logic [63:0] stream);
    logic [15:0] cap = '0;
    cs_n = 1'b0; quiet = 0;
    waitc(HALF);
    for (int i = 0; i < n; i++) begin
      if (mode11) sclk = 1'b0;
      dio_in = stream[n-1-i];
      quiet = 0;
      waitc(HALF);
      if (i < 16) cap = {cap[14:0], dio_out};
      sclk = 1'b1; quiet = 0;
      waitc(HALF);
      if (!mode11) begin sclk = 1'b0; quiet = 0; end
    end
    waitc(HALF);
    cs_n = 1'b1; quiet = 0;
    model_end(n, stream, cap);
    waitc(2 * HALF);
  endtask

  task automatic state(string req);
    chk(req, "gain", int'(gain_code), ex_gain);
    chk(req, "chan", int'(chan_code), ex_chan);
    chk(req, "shutdown", int'(shutdown), ex_sdn);
    chk(req, "oe idle", int'(dio_oe), 0);
  endtask

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(3);
    state("R1");
    cmp_on = 1;

    // R2 mode 0,0 write
    frame(0, 16, 64'h2A53);
    state("R2");
    // R9 mode 1,1 write
    set_idle(1);
    frame(1, 16, 64'h2A9C);
    state("R9");
    // R3 bad counts
    set_idle(0);
    frame(0, 15, 64'h2A11);
    state("R3");
    frame(0, 17, 64'h2A11);
    state("R3");
    frame(0, 0, 64'h0);
    state("R3");
    // R4 long frames
    frame(0, 32, 64'h2A11_2A7E);
    state("R4");
    frame(0, 32, 64'h2A22_0000);
    state("R4");
    // R5 / R6 shutdown
    frame(0, 16, 64'hE1F1);
    state("R5");
    frame(0, 16, 64'hE100);
    state("R6");
    frame(0, 16, 64'hE1F1);
    frame(0, 16, 64'h2A46);
    state("R6");
    // R10 no-ops
    frame(0, 16, 64'h6A01);
    frame(0, 16, 64'h1234);
    frame(0, 16, 64'h0000);
    state("R10");
    // R7 read-back mode 0,0; read-back frame carries a write that is ignored (R8)
    frame(0, 16, 64'h6A00);
    frame(0, 16, 64'h2AFF);
    state("R8");
    // R8 invalid frame keeps armed state, R7 read-back in mode 1,1
    frame(0, 16, 64'h2AB5);
    frame(0, 16, 64'h6A00);
    frame(0, 9, 64'h0);
    chk("R8", "armed after short frame", ex_pend, 1);
    set_idle(1);
    frame(1, 16, 64'h0);
    state("R9");
    // R7 32-clock read-back frame
    frame(1, 16, 64'h6A00);
    frame(1, 32, 64'h0);
    state("R7");
    set_idle(0);
    frame(0, 16, 64'h2A0C);
    state("R2");

    done = 1;
    summary();
    $finish;
  end
endmodule